// File: doc/BRIEF.md
# Stepped Soft-Start Sequencer

This block paces the start of a switched-mode power converter. Once the supply comes up, it steps a duty-limit reference up from zero in 32 equal steps. Each step is held for a fixed number of microsecond ticks, so the whole ramp takes about 20 ms. The reference leaves the block as a 5-bit step code, which drives the control of an analog current sink. The sink and the comparator that act on the code are outside the block.

A flag is high while the ramp is running. When the ramp finishes, the flag drops and a frequency-jitter enable rises. This enable lets the oscillator sweep its frequency by ±4% around nominal over a 4 ms period.

An undervoltage condition on the supply returns the block at once to an idle state with a zero code. Every auto-restart attempt runs the ramp again from zero. A restart request is acted on at the next microsecond tick.

Top module: `soft_start_seq`

## Requirements
- R1: A one-cycle `supply_up` pulse, with `supply_low` low, makes `ss_active` high and `step_code` 0 at the next clock edge; `ramp_done` goes low at that edge.
- R2: While `ss_active` is high, `step_code` rises by exactly one after every TICKS_PER_STEP clock edges at which `tick_us` is high. With the default of 600, step n is first shown after n*600 ticks.
- R3: `step_code` changes only at edges where `tick_us`, `supply_up` or `supply_low` is high; without a tick the code holds.
- R4: After TICKS_PER_STEP ticks spent at step 31, `ss_active` falls and `ramp_done` rises at the same edge. The total is 32*600 = 19200 ticks from the start.
- R5: After completion, `step_code` stays at 31 (all ones) and does not wrap, however many further ticks arrive.
- R6: `supply_low` high clears `step_code` to 0 and drops `ss_active` and `ramp_done` at the next edge. It also discards any pending restart. The block then stays idle under ticks until the next `supply_up`.
- R7: A `restart_req` pulse does not change the outputs until the next clock edge with `tick_us` high. At that edge `step_code` becomes 0, `ss_active` rises and `ramp_done` falls, whether the ramp was running or finished.
- R8: After a restart, the ramp repeats in full from step 0 with the step timing of R2.
- R9: `ss_active` and `ramp_done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_us | input | 1 | One-cycle microsecond time base |
| supply_up | input | 1 | Pulse: supply crossed the turn-on level |
| supply_low | input | 1 | Level: supply below the turn-off level |
| restart_req | input | 1 | Pulse: auto-restart attempt begins |
| step_code | output | STEP_W (5) | Duty-limit reference step, 0 to 31 |
| ss_active | output | 1 | Soft-start ramp in progress |
| ramp_done | output | 1 | Ramp complete; frequency jitter enabled |

## Verification
A wrong step counter shows on `step_code` at the very next step boundary, either as a skipped or repeated code or as a wrap to zero after step 31. A wrong tick divider shows only as a boundary that arrives early or late. The bench therefore samples one edge before and one edge at each boundary it checks, so that an off-by-one divider is visible within one step of 600 ticks. A restart or undervoltage flag held in the wrong state shows one tick later: either the code fails to return to zero, or the block ramps again while it should stay idle.

// File: rtl/soft_start_seq.sv
module soft_start_seq #(
  parameter int TICKS_PER_STEP = 600,
  parameter int STEPS          = 32,
  parameter int STEP_W         = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              supply_up,
  input  logic              supply_low,
  input  logic              restart_req,
  output logic [STEP_W-1:0] step_code,
  output logic              ss_active,
  output logic              ramp_done
);
  localparam int CNT_W = $clog2(TICKS_PER_STEP);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(TICKS_PER_STEP - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

  logic [CNT_W-1:0] tick_cnt;
  logic             restart_pend;
  logic             step_edge;

  assign step_edge = tick_us && ss_active && (tick_cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_code    <= '0;
      tick_cnt     <= '0;
      ss_active    <= 1'b0;
      ramp_done    <= 1'b0;
      restart_pend <= 1'b0;
    end else if (supply_low) begin
      step_code    <= '0;
      tick_cnt     <= '0;
      ss_active    <= 1'b0;
      ramp_done    <= 1'b0;
      restart_pend <= 1'b0;
    end else if (supply_up) begin
      step_code    <= '0;
      tick_cnt     <= '0;
      ss_active    <= 1'b1;
      ramp_done    <= 1'b0;
      restart_pend <= 1'b0;
    end else if (tick_us && (restart_pend || restart_req)) begin
      step_code    <= '0;
      tick_cnt     <= '0;
      ss_active    <= 1'b1;
      ramp_done    <= 1'b0;
      restart_pend <= 1'b0;
    end else begin
      if (restart_req) restart_pend <= 1'b1;
      if (tick_us && ss_active) begin
        if (step_edge) begin
          tick_cnt <= '0;
          if (step_code == STEP_LAST) begin
            ss_active <= 1'b0;
            ramp_done <= 1'b1;
          end else begin
            step_code <= step_code + 1'b1;
          end
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end
  end
endmodule

module soft_start_seq_chk #(
  parameter int STEP_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_us,
  input logic              supply_up,
  input logic              supply_low,
  input logic [STEP_W-1:0] step_code,
  input logic              ss_active,
  input logic              ramp_done
);
  localparam logic [STEP_W-1:0] ALL_ONES = '1;

  assert_start_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_up && !supply_low) |=> (ss_active && step_code == '0 && !ramp_done));

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(step_code)) |-> (step_code == $past(step_code) + 1'b1 || step_code == '0));

  assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_us && !supply_up && !supply_low) |=> $stable(step_code));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |-> step_code == ALL_ONES);

  assert_uvlo_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> (step_code == '0 && !ss_active && !ramp_done));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ss_active && ramp_done));
endmodule

bind soft_start_seq soft_start_seq_chk #(.STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .supply_up(supply_up),
  .supply_low(supply_low), .step_code(step_code), .ss_active(ss_active),
  .ramp_done(ramp_done)
);

// File: tb/soft_start_seq_test.sv
module soft_start_seq_test;
  localparam int TPS = 600;
  localparam int NST = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_us = 1'b0;
  logic       supply_up = 1'b0;
  logic       supply_low = 1'b0;
  logic       restart_req = 1'b0;
  logic [4:0] step_code;
  logic       ss_active;
  logic       ramp_done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  soft_start_seq uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .supply_up(supply_up),
    .supply_low(supply_low), .restart_req(restart_req),
    .step_code(step_code), .ss_active(ss_active), .ramp_done(ramp_done)
  );

  task automatic expect_out(input string req, input int code, input bit act, input bit done);
    checks++;
    if (step_code !== 5'(code) || ss_active !== act || ramp_done !== done) begin
      errors++;
      $display("FAIL %s: got code=%0d act=%0b done=%0b, expected code=%0d act=%0b done=%0b",
               req, step_code, ss_active, ramp_done, code, act, done);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_ramp();
    tick_us = 1'b1;
    supply_up = 1'b1;
    run(1);
    supply_up = 1'b0;
  endtask

  task automatic t_reset();
    run(2);
    expect_out("reset", 0, 0, 0);
    rst_n = 1'b1;
    tick_us = 1'b1;
    run(50);
    expect_out("R6 idle before start", 0, 0, 0);
  endtask

  task automatic t_ramp_full();
    start_ramp();
    expect_out("R1", 0, 1, 0);
    run(TPS - 1);
    expect_out("R2 one before step 1", 0, 1, 0);
    run(1);
    expect_out("R2 step 1", 1, 1, 0);
    run(TPS * 4);
    expect_out("R2 step 5", 5, 1, 0);
    run(TPS * (NST - 5) - 1);
    expect_out("R4 last edge before done", 31, 1, 0);
    run(1);
    expect_out("R4 done", 31, 0, 1);
    run(TPS * 3);
    expect_out("R5 saturated", 31, 0, 1);
  endtask

  task automatic t_tick_gate();
    start_ramp();
    run(TPS * 2 + 10);
    tick_us = 1'b0;
    run(TPS * 2);
    expect_out("R3 hold without tick", 2, 1, 0);
    tick_us = 1'b1;
    run(TPS - 10 - 1);
    expect_out("R3 resume before step 3", 2, 1, 0);
    run(1);
    expect_out("R3 resume step 3", 3, 1, 0);
  endtask

  task automatic t_restart_mid();
    tick_us = 1'b0;
    restart_req = 1'b1;
    run(1);
    restart_req = 1'b0;
    run(3);
    expect_out("R7 waits for tick", 3, 1, 0);
    tick_us = 1'b1;
    run(1);
    expect_out("R7 restart on tick", 0, 1, 0);
    run(TPS - 1);
    expect_out("R8 one before step 1", 0, 1, 0);
    run(1);
    expect_out("R8 step 1", 1, 1, 0);
  endtask

  task automatic t_restart_after_done();
    run(TPS * NST);
    expect_out("R4 done after restart", 31, 0, 1);
    tick_us = 1'b0;
    restart_req = 1'b1;
    run(1);
    restart_req = 1'b0;
    run(2);
    expect_out("R7 done holds until tick", 31, 0, 1);
    tick_us = 1'b1;
    run(1);
    expect_out("R7 restart from done", 0, 1, 0);
  endtask

  task automatic t_uvlo();
    run(TPS * 3);
    tick_us = 1'b0;
    restart_req = 1'b1;
    run(1);
    restart_req = 1'b0;
    supply_low = 1'b1;
    run(1);
    expect_out("R6 uvlo clears", 0, 0, 0);
    supply_low = 1'b0;
    tick_us = 1'b1;
    run(TPS * 2);
    expect_out("R6 stays idle, pending dropped", 0, 0, 0);
    start_ramp();
    expect_out("R1 restart after uvlo", 0, 1, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_ramp_full();
        t_tick_gate();
        t_restart_mid();
        t_restart_after_done();
        t_uvlo();
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule